// File: doc/BRIEF.md
# Run-Length Sample Packer

This block sits between a capture store and a host link. It accepts wide logic-analyzer samples, one per handshake, and turns them into a stream of bytes. Each sample is viewed as a set of 8-bit channel groups. A group that is switched off is never put on the wire, so a sample costs between zero and four bytes. The upstream reader delivers samples newest first. The packer keeps that arrival order and does not reorder anything itself.

When compression is on, runs of identical samples collapse to a pair of words. The first word is a plain sample with its top bit clear. The second is a count word with its top bit set, and its lower bits hold how many more times that sample repeated. Count and plain words travel through the same group selection. The configuration inputs (`rle_en`, `grp_off`) must be held steady for the whole of a stream, and `in_last` marks the final sample of a stream so that any pending count is flushed.

Both data interfaces use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. The sender must hold valid and data until that edge. `in_ready` depends only on internal state. `out_valid` and `out_data` come from registers and do not change while `out_ready` is low.

Top module: `sample_run_packer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The bytes of each word are sent from group 0 upward, where group g is bits [8g+7:8g]. A group with `grp_off[g]`=1 is skipped. A word therefore yields as many bytes as `grp_off` has zero bits.
- R3: With `rle_en`=0, every sample is sent as one unchanged 32-bit word, bit 31 included, and no count words are produced.
- R4: With `rle_en`=1, a run of L samples whose bits 30:0 are equal is sent as a plain word {0, sample[30:0]}. If L>1, this is followed by a count word {1, L-1}. A run of one has no count word.
- R5: With `rle_en`=1, the input's bit 31 is ignored: it takes no part in the comparison, and plain words always carry 0 in bit 31.
- R6: A count word never exceeds parameter `MAX_RUN` (default 2^31-1). A run longer than `MAX_RUN`+1 is split into consecutive plain/count pairs of `MAX_RUN`+1 samples each, with the remainder sent as a final pair or a lone plain word.
- R7: A sample accepted with `in_last`=1 ends the stream. Any pending count is sent, and the next sample starts fresh without comparison to earlier samples.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R9: Every count word immediately follows a plain word and carries a value from 1 to `MAX_RUN`.
- R10: With all four groups disabled, samples are still accepted and no byte is produced.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rle_en | input | 1 | Run-length compression enable |
| grp_off | input | 4 | Channel-group disable, bit g drops group g |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Packer can accept a sample |
| in_data | input | 32 | Sample value |
| in_last | input | 1 | Sample is the last of its stream |
| out_valid | output | 1 | Byte valid |
| out_ready | input | 1 | Host link accepts the byte |
| out_data | output | 8 | Output byte |

## Verification
The assertions in the RTL check four things on every cycle:
- the output byte is held while back-pressure is applied;
- a count word only ever follows a plain word, and its value lies between 1 and the saturation limit;
- each word released by the byte lane has produced exactly as many bytes as it had enabled groups.

Only the bench's scenarios can show the exact byte values and their group order, the grouping of runs into pairs, the split at saturation, the handling of bit 31 and the flush at the end of a stream. It compares every output byte with a model built from the requirements. For these scenarios it uses a reduced saturation limit together with random gaps and random back-pressure.

// File: rtl/rlp_pkg.sv
package rlp_pkg;
  // Kind of word handed from the run coder to the byte lane.
  typedef enum logic {
    WK_PLAIN = 1'b0,
    WK_COUNT = 1'b1
  } word_kind_e;
endpackage

// File: rtl/rlp_run_coder.sv
module rlp_run_coder
  import rlp_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned MAX_RUN = 32'h7FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rle_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  input  logic              word_take
);
  localparam int unsigned CNT_W = WORD_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RUN);

  logic              word_v;
  logic [WORD_W-1:0] word_q;
  word_kind_e        kind_q;
  word_kind_e        prev_kind_q;
  logic              stash_v;
  logic [CNT_W-1:0]  stash_q;
  logic              have_prev;
  logic [CNT_W-1:0]  prev_q;
  logic [CNT_W-1:0]  cnt_q;

  logic              take_in;
  logic [CNT_W-1:0]  smp;
  logic [CNT_W-1:0]  cnt_inc;
  logic              same;

  assign in_ready   = !word_v && !stash_v;
  assign take_in    = in_valid && in_ready;
  assign smp        = in_data[CNT_W-1:0];
  assign cnt_inc    = cnt_q + CNT_W'(1);
  assign same       = have_prev && (smp == prev_q);
  assign word_valid = word_v;
  assign word_data  = word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_v      <= 1'b0;
      word_q      <= '0;
      kind_q      <= WK_PLAIN;
      prev_kind_q <= WK_COUNT;
      stash_v     <= 1'b0;
      stash_q     <= '0;
      have_prev   <= 1'b0;
      prev_q      <= '0;
      cnt_q       <= '0;
    end else begin
      // Slot drain: a stashed sample follows the count word out.
      if (word_v && word_take) begin
        prev_kind_q <= kind_q;
        if (stash_v) begin
          word_q  <= {1'b0, stash_q};
          kind_q  <= WK_PLAIN;
          stash_v <= 1'b0;
        end else begin
          word_v <= 1'b0;
        end
      end
      // New sample; only possible while the slot is empty.
      if (take_in) begin
        word_v <= 1'b1;
        if (!rle_en) begin
          word_q    <= in_data;
          kind_q    <= WK_PLAIN;
          have_prev <= 1'b0;
          cnt_q     <= '0;
        end else if (!have_prev) begin
          word_q    <= {1'b0, smp};
          kind_q    <= WK_PLAIN;
          prev_q    <= smp;
          cnt_q     <= '0;
          have_prev <= !in_last;
        end else if (same) begin
          if ((cnt_inc == CNT_MAX) || in_last) begin
            word_q    <= {1'b1, cnt_inc};
            kind_q    <= WK_COUNT;
            cnt_q     <= '0;
            have_prev <= 1'b0;
          end else begin
            cnt_q  <= cnt_inc;
            word_v <= 1'b0;
          end
        end else begin
          prev_q    <= smp;
          cnt_q     <= '0;
          have_prev <= !in_last;
          if (cnt_q != '0) begin
            word_q  <= {1'b1, cnt_q};
            kind_q  <= WK_COUNT;
            stash_v <= 1'b1;
            stash_q <= smp;
          end else begin
            word_q <= {1'b0, smp};
            kind_q <= WK_PLAIN;
          end
        end
      end
    end
  end

  // R9
  count_after_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_v && kind_q == WK_COUNT) |-> (prev_kind_q == WK_PLAIN));

  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_v && kind_q == WK_COUNT) |->
      ((word_q[CNT_W-1:0] != '0) && (word_q[CNT_W-1:0] <= CNT_MAX)));

endmodule

// File: rtl/rlp_byte_lane.sv
module rlp_byte_lane #(
  parameter int unsigned GROUPS  = 4,
  parameter int unsigned GROUP_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GROUPS-1:0]         grp_off,
  input  logic                      word_valid,
  input  logic [GROUPS*GROUP_W-1:0] word_data,
  output logic                      word_take,
  output logic                      out_valid,
  output logic [GROUP_W-1:0]        out_data,
  input  logic                      out_ready
);
  localparam int unsigned WORD_W = GROUPS * GROUP_W;
  localparam int unsigned SEL_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int unsigned SENT_W = $clog2(GROUPS + 1);

  logic [WORD_W-1:0] data_q;
  logic [GROUPS-1:0] rem_q;
  logic [GROUPS-1:0] en_q;
  logic [SENT_W-1:0] sent_q;
  logic              loaded_q;

  logic [SEL_W-1:0]  sel;
  logic              fire;
  logic [GROUPS-1:0] rem_after;

  // Lowest remaining enabled group goes out first.
  always_comb begin
    sel = '0;
    for (int g = GROUPS - 1; g >= 0; g--) begin
      if (rem_q[g]) sel = SEL_W'(g);
    end
  end

  assign out_valid = |rem_q;
  assign out_data  = data_q[int'(sel)*GROUP_W +: GROUP_W];
  assign fire      = out_valid && out_ready;
  assign rem_after = fire ? (rem_q & (rem_q - GROUPS'(1))) : rem_q;
  assign word_take = word_valid && (rem_after == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      rem_q    <= '0;
      en_q     <= '0;
      sent_q   <= '0;
      loaded_q <= 1'b0;
    end else if (word_take) begin
      data_q   <= word_data;
      rem_q    <= ~grp_off;
      en_q     <= ~grp_off;
      sent_q   <= '0;
      loaded_q <= 1'b1;
    end else begin
      rem_q <= rem_after;
      if (fire) sent_q <= sent_q + SENT_W'(1);
    end
  end

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  bytes_per_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_take && loaded_q) |->
      ((int'(sent_q) + (fire ? 1 : 0)) == $countones(en_q)));

endmodule

// File: rtl/sample_run_packer.sv
module sample_run_packer #(
  parameter int unsigned GROUPS  = 4,
  parameter int unsigned GROUP_W = 8,
  parameter int unsigned MAX_RUN = 32'h7FFF_FFFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rle_en,
  input  logic [GROUPS-1:0]         grp_off,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [GROUPS*GROUP_W-1:0] in_data,
  input  logic                      in_last,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [GROUP_W-1:0]        out_data
);
  localparam int unsigned WORD_W = GROUPS * GROUP_W;

  logic              word_valid;
  logic [WORD_W-1:0] word_data;
  logic              word_take;

  rlp_run_coder #(
    .WORD_W (WORD_W),
    .MAX_RUN(MAX_RUN)
  ) coder_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rle_en    (rle_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .word_valid(word_valid),
    .word_data (word_data),
    .word_take (word_take)
  );

  rlp_byte_lane #(
    .GROUPS (GROUPS),
    .GROUP_W(GROUP_W)
  ) lane_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_off   (grp_off),
    .word_valid(word_valid),
    .word_data (word_data),
    .word_take (word_take),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready));

endmodule

// File: tb/sample_run_packer_tb_top.sv
module sample_run_packer_tb_top;
  localparam int MAXR = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rle_en = 1'b0;
  logic [3:0]  grp_off = 4'h0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;

  int tests = 0;
  int fails = 0;

  logic [31:0] stim[$];
  logic [7:0]  exp_b[$];

  always #5 clk = ~clk;

  sample_run_packer #(.MAX_RUN(MAXR)) dut_i (
    .clk(clk), .rst_n(rst_n), .rle_en(rle_en), .grp_off(grp_off),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Model: words per R3/R4/R5/R6, bytes per R2.
  function automatic void build_exp(input bit rle, input logic [3:0] off);
    logic [31:0] words[$];
    int n = stim.size();
    int i = 0;
    exp_b.delete();
    if (!rle) begin
      foreach (stim[k]) words.push_back(stim[k]);
    end else begin
      while (i < n) begin
        logic [30:0] v = stim[i][30:0];
        int len = 1;
        int left;
        while (i + len < n && stim[i+len][30:0] == v) len++;
        left = len;
        while (left > 0) begin
          int ch = (left > MAXR + 1) ? MAXR + 1 : left;
          words.push_back({1'b0, v});
          if (ch > 1) words.push_back({1'b1, 31'(ch - 1)});
          left -= ch;
        end
        i += len;
      end
    end
    foreach (words[k])
      for (int g = 0; g < 4; g++)
        if (!off[g]) exp_b.push_back(words[k][8*g +: 8]);
  endfunction

  task automatic run_stream(input bit rle, input logic [3:0] off, input string req, input int bp);
    int n = stim.size();
    int sent = 0;
    int got = 0;
    int idle = 0;
    bit hold_v = 0;
    logic [7:0] hold_d = '0;
    build_exp(rle, off);
    @(negedge clk);
    rle_en = rle;
    grp_off = off;
    while (idle < 40) begin
      @(negedge clk);
      if (sent < n) begin
        in_valid = ($urandom % 4) != 0;
        in_data  = stim[sent];
        in_last  = (sent == n - 1);
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      out_ready = ($urandom % 100) < bp;
      #1;
      if (hold_v) begin
        check("R8 held byte", {23'd0, out_valid, out_data}, {23'd0, 1'b1, hold_d});
        hold_v = 0;
      end
      if (in_valid && in_ready) sent++;
      if (out_valid && out_ready) begin
        if (got < exp_b.size()) check(req, {24'd0, out_data}, {24'd0, exp_b[got]});
        else check({req, " extra byte"}, {24'd0, out_data}, 32'hFFFF_FFFF);
        got++;
      end else if (out_valid) begin
        hold_v = 1;
        hold_d = out_data;
      end
      if (sent == n && !out_valid) idle++;
      else idle = 0;
    end
    in_valid = 1'b0;
    out_ready = 1'b0;
    check({req, " byte count"}, got, exp_b.size());
    check("R10 all samples accepted", sent, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: raw words, bit 31 kept
    stim.delete();
    for (int k = 0; k < 20; k++) stim.push_back($urandom);
    stim.push_back(32'h8000_0000);
    run_stream(0, 4'b0000, "R3 raw word", 70);

    // R2: group dropping and order
    stim.delete();
    for (int k = 0; k < 12; k++) stim.push_back($urandom);
    run_stream(0, 4'b0101, "R2 groups 1,3", 60);
    run_stream(0, 4'b1110, "R2 group 0 only", 50);
    run_stream(0, 4'b1000, "R2 groups 0-2", 90);

    // R10: everything disabled
    run_stream(0, 4'b1111, "R10 no bytes", 70);
    run_stream(1, 4'b1111, "R10 no bytes rle", 70);

    // R4: directed runs
    stim.delete();
    stim = '{32'h11, 32'h11, 32'h11, 32'h22, 32'h33, 32'h33};
    run_stream(1, 4'b0000, "R4 runs", 60);
    stim = '{32'h0ABC_DEF0};
    run_stream(1, 4'b0000, "R4 single", 60);

    // R5: bit 31 ignored in compare and cleared
    stim = '{32'h8000_0011, 32'h0000_0011, 32'hFFFF_FFFF};
    run_stream(1, 4'b0000, "R5 bit31 ignored", 70);

    // R6: saturation splits
    stim.delete();
    for (int k = 0; k < 15; k++) stim.push_back(32'h5A5A_5A5A);
    run_stream(1, 4'b0000, "R6 saturation 15", 70);
    stim.delete();
    for (int k = 0; k < 7; k++) stim.push_back(32'h0000_0007);
    stim.push_back(32'h0000_0008);
    run_stream(1, 4'b0000, "R6 saturation exact", 50);

    // R7: a new stream does not continue the previous run
    stim = '{32'h44, 32'h44};
    run_stream(1, 4'b0000, "R7 flush at last", 70);
    stim = '{32'h44};
    run_stream(1, 4'b0000, "R7 fresh stream", 70);

    // Random RLE streams, small alphabet for runs (R4, R6, R9)
    for (int r = 0; r < 8; r++) begin
      stim.delete();
      for (int k = 0; k < 40; k++) begin
        logic [31:0] v = {$urandom % 2 == 0, 29'd0, 2'($urandom % 3)};
        int rep = $urandom % 10;
        for (int j = 0; j <= rep; j++) stim.push_back(v);
      end
      run_stream(1, 4'($urandom % 15), "R4 random runs", 40 + 10 * r);
    end

    // R8: heavy back-pressure on raw data
    stim.delete();
    for (int k = 0; k < 16; k++) stim.push_back($urandom);
    run_stream(0, 4'b0000, "R8 stalled stream", 15);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule